// File: doc/BRIEF.md
# Half-Rate Direct Digital Sine Synthesiser

This block is a direct digital synthesis core that produces a stream of 8-bit unsigned sine samples for an external DAC. A 16-bit frequency word is captured from a data bus on a load strobe. A 21-bit phase register adds that word once every second clock cycle. The output frequency is therefore `f_clk * word / 2^22`. The smallest step is `f_clk / 2^22`, about 5.96 Hz at 25 MHz. The practical ceiling is about `f_clk / 2^6`.

The eight most significant phase bits address a full-cycle sine table of 256 entries. The table is computed when the design is elaborated and is centred on code 128. A 2-bit gain code scales the swing about mid-scale to one, two, three or four quarters of full amplitude. Each scaled sample is registered. A one-cycle valid pulse marks each phase update. Loading a new word changes only the step size and never the current phase, so the waveform has no phase jump.

Top module: `dds_sine_gen`

## Requirements
- R1: A load changes only the frequency word and never the phase register. The phase moves only on an update cycle.
- R2: After reset is released, a phase update happens on every second clock cycle, starting with the second edge. `smp_vld` is high for exactly the cycle after each update edge and is low otherwise.
- R3: On each update, the phase register becomes (phase + word) modulo 2^21, with the word zero-extended.
- R4: On a rising edge with `ld_en` high, the frequency word takes `ld_word`. Without `ld_en`, the word holds its value. An update on the same edge as a load still uses the old word.
- R5: The table index is phase bits [20:13]. The table entry for index k is round(128 + 127*sin(2*pi*k/256)), so entries lie in the range 1 to 255.
- R6: On an update edge, the sample register takes 128 + floor(d*(g+1)/4). Here d is the table entry minus 128, taken at the phase before the update, and g is the value of `gain_sel` at that edge.
- R7: Synchronous reset clears the phase register, the frequency word and the update toggle. It sets `smp_out` to 128 and `smp_vld` to 0.
- R8: With a frequency word of zero, `smp_out` stays at 128 for every gain code.
- R9: `smp_out` changes only on the cycles when `smp_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Strobe that captures `ld_word` as the frequency word |
| ld_word | input | 16 | New frequency word |
| gain_sel | input | 2 | Amplitude code: 0 gives 1/4, 3 gives full amplitude |
| smp_out | output | 8 | Unsigned sample for the DAC, mid-scale 128 |
| smp_vld | output | 1 | One-cycle pulse after each phase update |

## Verification
The assertions rely on the control inputs being steady at each rising edge. They also rely on reset being held from time zero until the first edges have passed, so that every `$past` value comes from a reset state. The bench changes `ld_en`, `ld_word` and `gain_sel` only on falling edges, and it holds reset for several cycles at the start. Loads land on both the update and the idle phase of the toggle, so both cases of the same-edge ordering are reached. Gain codes are swept while the phase is moving.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int FWORD_W  = 16;
  localparam int PHASE_W  = 21;
  localparam int ADDR_W   = 8;
  localparam int SAMPLE_W = 8;
  localparam int GAIN_W   = 2;
  localparam int RATE_DIV = 2;
  localparam int MID_CODE = 1 << (SAMPLE_W - 1);
  localparam int EXT_W    = SAMPLE_W + 3;

  // Table entry for index idx of a 2^aw point cycle, centred on mid-scale.
  function automatic logic [SAMPLE_W-1:0] sine_code(input int idx, input int aw);
    real ang;
    real amp;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(1 << aw);
    amp = real'(MID_CODE - 1);
    return SAMPLE_W'($rtoi(real'(MID_CODE) + amp * $sin(ang) + 0.5));
  endfunction

  // Scale the signed deviation from mid-scale by (g+1)/4, floor, re-centre.
  function automatic logic [SAMPLE_W-1:0] scale_code(input logic [SAMPLE_W-1:0] s,
                                                     input logic [GAIN_W-1:0] g);
    logic signed [EXT_W-1:0] dev;
    logic signed [EXT_W-1:0] prod;
    logic signed [EXT_W-1:0] res;
    logic [GAIN_W:0]         mult;
    mult = {1'b0, g} + 1'b1;
    dev  = $signed({3'b000, s}) - $signed(EXT_W'(MID_CODE));
    prod = dev * $signed({{(EXT_W-GAIN_W-1){1'b0}}, mult});
    res  = (prod >>> GAIN_W) + $signed(EXT_W'(MID_CODE));
    return res[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/dds_rate_gen.sv
module dds_rate_gen #(
  parameter int DIV = dds_pkg::RATE_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int FW = dds_pkg::FWORD_W,
  parameter int PW = dds_pkg::PHASE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [FW-1:0] word_i,
  output logic [PW-1:0] phase_o,
  output logic [FW-1:0] word_o
);
  localparam int PAD = PW - FW;

  logic [FW-1:0] word_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (ld_i) word_q <= word_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + {{PAD{1'b0}}, word_q};
  end

  assign phase_o = phase_q;
  assign word_o  = word_q;
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int AW = dds_pkg::ADDR_W,
  parameter int SW = dds_pkg::SAMPLE_W
) (
  input  logic [AW-1:0] addr_i,
  output logic [SW-1:0] code_o
);
  localparam int DEPTH = 1 << AW;

  logic [SW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [SW-1:0] VAL = dds_pkg::sine_code(i, AW);
    assign tbl[i] = VAL;
  end

  assign code_o = tbl[addr_i];
endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int FW  = dds_pkg::FWORD_W,
  parameter int PW  = dds_pkg::PHASE_W,
  parameter int AW  = dds_pkg::ADDR_W,
  parameter int SW  = dds_pkg::SAMPLE_W,
  parameter int GW  = dds_pkg::GAIN_W,
  parameter int DIV = dds_pkg::RATE_DIV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [FW-1:0] ld_word,
  input  logic [GW-1:0] gain_sel,
  output logic [SW-1:0] smp_out,
  output logic          smp_vld
);
  localparam logic [SW-1:0] MID = SW'(dds_pkg::MID_CODE);

  // Internal events brought out as named wires
  logic          upd_tick;
  logic [PW-1:0] phase_w;
  logic [FW-1:0] word_w;
  logic [SW-1:0] raw_code;
  logic [SW-1:0] scaled_code;
  logic [SW-1:0] smp_q;
  logic          vld_q;

  dds_rate_gen #(.DIV(DIV)) u_rate (
    .clk    (clk),
    .rst    (rst),
    .tick_o (upd_tick)
  );

  dds_phase_acc #(.FW(FW), .PW(PW)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (upd_tick),
    .ld_i    (ld_en),
    .word_i  (ld_word),
    .phase_o (phase_w),
    .word_o  (word_w)
  );

  dds_sine_rom #(.AW(AW), .SW(SW)) u_rom (
    .addr_i (phase_w[PW-1 -: AW]),
    .code_o (raw_code)
  );

  assign scaled_code = dds_pkg::scale_code(raw_code, gain_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= MID;
      vld_q <= 1'b0;
    end else begin
      vld_q <= upd_tick;
      if (upd_tick) smp_q <= scaled_code;
    end
  end

  assign smp_out = smp_q;
  assign smp_vld = vld_q;
endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
  parameter int FW = dds_pkg::FWORD_W,
  parameter int PW = dds_pkg::PHASE_W,
  parameter int SW = dds_pkg::SAMPLE_W,
  parameter int GW = dds_pkg::GAIN_W
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_en,
  input logic [FW-1:0] ld_word,
  input logic [GW-1:0] gain_sel,
  input logic [SW-1:0] smp_out,
  input logic          smp_vld,
  input logic          upd_tick,
  input logic [PW-1:0] phase_w,
  input logic [FW-1:0] word_w
);
  localparam int PAD = PW - FW;

  assert_vld_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
    upd_tick |=> smp_vld);
  assert_no_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_tick |=> !smp_vld);
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    upd_tick |=> !upd_tick);
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
    upd_tick |=> phase_w == PW'($past(phase_w) + {{PAD{1'b0}}, $past(word_w)}));
  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !upd_tick |=> $stable(phase_w));
  assert_load_capture_R4: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> word_w == $past(ld_word));
  assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(word_w));
  assert_sample_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |-> $stable(smp_out));
  assert_quarter_range_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $past(gain_sel) == '0) |-> (smp_out >= SW'(96) && smp_out <= SW'(159)));
  assert_never_zero_R5: assert property (@(posedge clk) disable iff (rst)
    smp_out != '0);
endmodule

bind dds_sine_gen dds_sine_gen_chk #(.FW(FW), .PW(PW), .SW(SW), .GW(GW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_en    (ld_en),
  .ld_word  (ld_word),
  .gain_sel (gain_sel),
  .smp_out  (smp_out),
  .smp_vld  (smp_vld),
  .upd_tick (upd_tick),
  .phase_w  (phase_w),
  .word_w   (word_w)
);

// File: tb/dds_sine_gen_tb.sv
module dds_sine_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [15:0] ld_word = '0;
  logic [1:0]  gain_sel = '0;
  logic [7:0]  smp_out;
  logic        smp_vld;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R7";

  // behavioural reference state
  int m_tog = 0;
  int m_phase = 0;
  int m_word = 0;
  int m_smp = 128;
  int m_vld = 0;

  always #5 clk = ~clk;

  dds_sine_gen u_dut (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_word  (ld_word),
    .gain_sel (gain_sel),
    .smp_out  (smp_out),
    .smp_vld  (smp_vld)
  );

  function automatic int ref_sine(int k);
    return int'(128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * k / 256.0));
  endfunction

  function automatic int ref_scale(int s, int g);
    int p;
    p = (s - 128) * (g + 1);
    if (p >= 0) return 128 + p / 4;
    return 128 - ((-p + 3) / 4);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_tog = 0; m_phase = 0; m_word = 0; m_smp = 128; m_vld = 0;
    end else begin
      m_vld = 0;
      if (m_tog == 1) begin
        m_smp = ref_scale(ref_sine(m_phase / 8192), int'(gain_sel));
        m_vld = 1;
        m_phase = (m_phase + m_word) % 2097152;
      end
      if (ld_en) m_word = int'(ld_word);
      m_tog = 1 - m_tog;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "smp_vld (R2)", int'(smp_vld), m_vld);
      check(cur_req, "smp_out (R5 R6 R9)", int'(smp_out), m_smp);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(int w);
    ld_word = 16'(w);
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset state at the ports
    check("R7", "reset smp_out", int'(smp_out), 128);
    check("R7", "reset smp_vld", int'(smp_vld), 0);
    rst = 1'b0;

    // R8: zero word keeps mid-scale for every gain
    cur_req = "R8";
    for (int g = 0; g < 4; g++) begin
      gain_sel = 2'(g);
      run(12);
      check("R8", "zero word level", int'(smp_out), 128);
    end

    // R5/R6: moving phase under each gain
    cur_req = "R5";
    gain_sel = 2'd3;
    load(16'h0800);
    run(600);
    cur_req = "R6";
    for (int g = 0; g < 4; g++) begin
      gain_sel = 2'(g);
      run(300);
    end

    // R4: loads on both toggle parities, same-edge ordering
    cur_req = "R4";
    load(16'h1234);
    run(7);
    load(16'h0321);
    load(16'h2000);
    run(9);

    // R1: repeated loads of changing words never jump the phase
    cur_req = "R1";
    for (int k = 0; k < 20; k++) load(16'h0100 + k * 16'h0111);
    run(50);

    // R3: largest word, fast wrap of the phase register
    cur_req = "R3";
    gain_sel = 2'd2;
    load(16'hFFFF);
    run(800);
    load(16'h0001);
    run(200);

    // R9 and R2: hold between pulses while gain toggles on idle cycles
    cur_req = "R9";
    load(16'h4000);
    for (int k = 0; k < 100; k++) begin
      gain_sel = 2'(k % 4);
      @(negedge clk);
    end

    // R7: reset mid-run returns to mid-scale
    cur_req = "R7";
    rst = 1'b1;
    run(3);
    check("R7", "re-reset smp_out", int'(smp_out), 128);
    check("R7", "re-reset smp_vld", int'(smp_vld), 0);
    rst = 1'b0;
    run(20);
    check("R7", "word cleared by reset", int'(smp_out), 128);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule